// File: doc/BRIEF.md
# Shared-Row LED and Key Matrix Scanner

This block drives a 40-point LED display, arranged as 8 columns by 5 rows, and scans a 24-key switch matrix of 8 columns by 3 rows. Both matrices hang off a single 8-bit external bus. A 3-bit device select with a separate decoder enable picks the target on that bus. Three bus targets are used. Select 1 is a latch that drives the LED columns and sources their current. Select 2 is one row latch shared by both matrices: bits 4:0 sink the LED rows (active low) and bits 7:5 drive the key rows (active low). Select 3 is a readable port that returns the key column lines, and it is also the resting select.

Each pulse on `scan_tick` runs one step. A step shows one LED column and reads one key row into a 24-bit pressed-key map. The LED image is loaded one row byte at a time through a write port. The scanner never changes the select lines while the decoder is enabled. It blanks the LED columns before the row pattern moves, so no ghost image shows. Debouncing is left to the consumer of the key map.

Top module: `matrix_scanner`

## Requirements
- R1: After reset `bus_addr` is 3, `bus_dec_en` and `bus_data_oe` are 0, `bus_data_out` is 0 and every bit of `key_state` is 0.
- R2: A `scan_tick` seen while idle starts a step of exactly four accesses. In order they are: select 1 with data 0x00 (blank), select 2 (row latch), select 1 (column pattern), select 3 (key read). Each access is 3 cycles: select set, enable high for one cycle, enable low. The step takes 12 cycles, then the block returns to select 3 with the enable low.
- R3: `bus_addr` changes only in a cycle where `bus_dec_en` is 0 and was also 0 in the cycle before.
- R4: `bus_data_oe` is 1 for the whole of every write access. It is 0 whenever select 3 is on `bus_addr`, so the bus is released for reading.
- R5: Steps visit LED columns 0,1,…,7 and then wrap to 0. In the step for column c, the column-pattern write carries only bit c set. In the row-latch write, bit r (r = 0..4) is 0 exactly when the LED at row r, column c is on.
- R6: Steps visit key rows 0,1,2 and then wrap to 0, independently of the LED column. In the step for key row s, bits 7:5 of the row-latch write are all 1 except bit 5+s, which is 0.
- R7: In a step for key row s, `key_state[8*s+c]` becomes 1 when bit c of `bus_data_in` is 0 during the key-read enable cycle, and 0 otherwise. The other rows of `key_state` keep their values.
- R8: A cycle with `led_wr_en` = 1 stores `led_wr_data` as LED row `led_wr_row`, where bit c is column c and 1 means on. Row indexes 5 to 7 are ignored.
- R9: A `scan_tick` that arrives while a step is in progress is ignored: it neither adds accesses nor advances the column or key-row sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle request to run the next scan step |
| led_wr_en | input | 1 | LED image row write strobe |
| led_wr_row | input | 3 | LED row index to write |
| led_wr_data | input | 8 | LED row pattern, bit c = column c on |
| key_state | output | 24 | Pressed map, bit 8*row+column |
| bus_addr | output | 3 | External device select |
| bus_dec_en | output | 1 | Select decoder enable |
| bus_data_out | output | 8 | Data driven onto the shared bus |
| bus_data_oe | output | 1 | Bus drive enable; 0 releases the bus |
| bus_data_in | input | 8 | Shared bus value as read back |

## Verification
The hardest case to reach from the ports is a key read that depends on the row latch the block itself wrote two accesses earlier. The bench therefore models the external latches. It captures each enabled write from the bus and derives `bus_data_in` from its own key matrix and the captured row bits, so a wrong row code shows up as wrong keys. A second tick is injected in the middle of a step to show that the sequence counters do not move. The bench also tracks each change of the select lines to catch any change made while the decoder is enabled.

// File: rtl/mxs_pkg.sv
package mxs_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] SEL_COLS = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_ROWS = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_KEYS = 3'd3;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef enum logic [1:0] {
        AC_BLANK,
        AC_ROWS,
        AC_COLS,
        AC_KEYS
    } access_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en;
        logic              oe;
        logic [BUS_W-1:0]  data;
    } bus_drive_t;

    function automatic logic [ADDR_W-1:0] access_sel(access_t a);
        case (a)
            AC_BLANK: return SEL_COLS;
            AC_ROWS:  return SEL_ROWS;
            AC_COLS:  return SEL_COLS;
            default:  return SEL_KEYS;
        endcase
    endfunction

endpackage

// File: rtl/mxs_led_store.sv
module mxs_led_store
    import mxs_pkg::*;
#(
    parameter int LED_COLS = 8,
    parameter int LED_ROWS = 5,
    parameter int IDX_W    = 3,
    localparam int COL_W   = $clog2(LED_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_row,
    input  logic [LED_COLS-1:0] wr_data,
    input  logic [COL_W-1:0]    col_idx,
    output logic [LED_ROWS-1:0] col_bits
);

    logic [LED_ROWS-1:0][LED_COLS-1:0] image_q;

    generate
        for (genvar r = 0; r < LED_ROWS; r++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) begin
                    image_q[r] <= '0;
                end else if (wr_en && (int'(wr_row) == r)) begin
                    image_q[r] <= wr_data;
                end
            end
            assign col_bits[r] = image_q[r][col_idx];
        end
    endgenerate

endmodule

// File: rtl/mxs_key_store.sv
module mxs_key_store
    import mxs_pkg::*;
#(
    parameter int KEY_COLS = 8,
    parameter int KEY_ROWS = 3,
    localparam int ROW_W   = $clog2(KEY_ROWS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cap_en,
    input  logic [ROW_W-1:0]             cap_row,
    input  logic [KEY_COLS-1:0]          col_lines,
    output logic [KEY_ROWS*KEY_COLS-1:0] pressed
);

    logic [KEY_ROWS-1:0][KEY_COLS-1:0] rows_q;

    generate
        for (genvar s = 0; s < KEY_ROWS; s++) begin : g_krow
            always_ff @(posedge clk) begin
                if (rst) begin
                    rows_q[s] <= '0;
                end else if (cap_en && (int'(cap_row) == s)) begin
                    rows_q[s] <= ~col_lines;
                end
            end
            assign pressed[s*KEY_COLS +: KEY_COLS] = rows_q[s];
        end
    endgenerate

endmodule

// File: rtl/mxs_sequencer.sv
module mxs_sequencer
    import mxs_pkg::*;
#(
    parameter int LED_COLS = 8,
    parameter int LED_ROWS = 5,
    parameter int KEY_ROWS = 3,
    localparam int COL_W   = $clog2(LED_COLS),
    localparam int ROW_W   = $clog2(KEY_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_tick,
    input  logic [LED_ROWS-1:0] led_col_bits,
    output logic [COL_W-1:0]    col_idx,
    output logic [ROW_W-1:0]    key_row_idx,
    output logic                cap_en,
    output bus_drive_t          drv
);

    logic       busy_q;
    access_t    acc_q;
    phase_t     ph_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] srow_q;
    logic       last_cycle;

    assign last_cycle = busy_q && (acc_q == AC_KEYS) && (ph_q == PH_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            acc_q  <= AC_BLANK;
            ph_q   <= PH_SETUP;
            col_q  <= '0;
            srow_q <= '0;
        end else if (!busy_q) begin
            if (scan_tick) begin
                busy_q <= 1'b1;
                acc_q  <= AC_BLANK;
                ph_q   <= PH_SETUP;
            end
        end else begin
            case (ph_q)
                PH_SETUP:  ph_q <= PH_STROBE;
                PH_STROBE: ph_q <= PH_HOLD;
                default: begin
                    ph_q <= PH_SETUP;
                    if (acc_q == AC_KEYS) begin
                        busy_q <= 1'b0;
                        acc_q  <= AC_BLANK;
                        col_q  <= (col_q == COL_W'(LED_COLS - 1)) ? '0 : col_q + 1'b1;
                        srow_q <= (srow_q == ROW_W'(KEY_ROWS - 1)) ? '0 : srow_q + 1'b1;
                    end else begin
                        acc_q <= access_t'(acc_q + 2'd1);
                    end
                end
            endcase
        end
    end

    logic [KEY_ROWS-1:0] key_sel;
    logic [LED_COLS-1:0] col_hot;

    assign key_sel = KEY_ROWS'(1) << srow_q;
    assign col_hot = LED_COLS'(1) << col_q;

    always_comb begin
        drv = '{addr: SEL_KEYS, en: 1'b0, oe: 1'b0, data: '0};
        if (busy_q) begin
            drv.addr = access_sel(acc_q);
            drv.en   = (ph_q == PH_STROBE);
            drv.oe   = (acc_q != AC_KEYS);
            case (acc_q)
                AC_ROWS: drv.data = {~key_sel, ~led_col_bits};
                AC_COLS: drv.data = col_hot;
                default: drv.data = '0;
            endcase
        end
    end

    assign cap_en      = busy_q && (acc_q == AC_KEYS) && (ph_q == PH_STROBE);
    assign col_idx     = col_q;
    assign key_row_idx = srow_q;

    a_r3_sel_quiet: assert property (@(posedge clk) disable iff (rst)
        (drv.addr != $past(drv.addr)) |-> (!drv.en && !$past(drv.en)));

    a_r2_one_cycle_strobe: assert property (@(posedge clk) disable iff (rst)
        drv.en |=> !drv.en);

    a_r5_col_onehot: assert property (@(posedge clk) disable iff (rst)
        (drv.en && drv.addr == SEL_COLS) |-> $onehot0(drv.data));

    a_r6_one_key_row: assert property (@(posedge clk) disable iff (rst)
        (drv.en && drv.addr == SEL_ROWS) |-> ($countones(drv.data[BUS_W-1 -: KEY_ROWS]) == KEY_ROWS - 1));

    a_r9_seq_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last_cycle) |=> ($stable(col_q) && $stable(srow_q)));

endmodule

// File: rtl/matrix_scanner.sv
module matrix_scanner
    import mxs_pkg::*;
#(
    parameter int LED_COLS = 8,
    parameter int LED_ROWS = 5,
    parameter int KEY_ROWS = 3,
    localparam int COL_W   = $clog2(LED_COLS),
    localparam int ROW_W   = $clog2(KEY_ROWS),
    localparam int KEYS    = KEY_ROWS * LED_COLS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan_tick,
    input  logic                led_wr_en,
    input  logic [2:0]          led_wr_row,
    input  logic [7:0]          led_wr_data,
    output logic [KEYS-1:0]     key_state,
    output logic [2:0]          bus_addr,
    output logic                bus_dec_en,
    output logic [7:0]          bus_data_out,
    output logic                bus_data_oe,
    input  logic [7:0]          bus_data_in
);

    logic [COL_W-1:0]    col_idx;
    logic [ROW_W-1:0]    key_row_idx;
    logic [LED_ROWS-1:0] col_bits;
    logic                cap_en;
    bus_drive_t          drv;

    mxs_led_store #(
        .LED_COLS(LED_COLS),
        .LED_ROWS(LED_ROWS),
        .IDX_W(3)
    ) u_leds (
        .clk(clk),
        .rst(rst),
        .wr_en(led_wr_en),
        .wr_row(led_wr_row),
        .wr_data(led_wr_data),
        .col_idx(col_idx),
        .col_bits(col_bits)
    );

    mxs_sequencer #(
        .LED_COLS(LED_COLS),
        .LED_ROWS(LED_ROWS),
        .KEY_ROWS(KEY_ROWS)
    ) u_seq (
        .clk(clk),
        .rst(rst),
        .scan_tick(scan_tick),
        .led_col_bits(col_bits),
        .col_idx(col_idx),
        .key_row_idx(key_row_idx),
        .cap_en(cap_en),
        .drv(drv)
    );

    mxs_key_store #(
        .KEY_COLS(LED_COLS),
        .KEY_ROWS(KEY_ROWS)
    ) u_keys (
        .clk(clk),
        .rst(rst),
        .cap_en(cap_en),
        .cap_row(key_row_idx),
        .col_lines(bus_data_in),
        .pressed(key_state)
    );

    assign bus_addr     = drv.addr;
    assign bus_dec_en   = drv.en;
    assign bus_data_oe  = drv.oe;
    assign bus_data_out = drv.data;

    a_r4_release_on_read: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SEL_KEYS) |-> !bus_data_oe);

    a_r4_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        (bus_dec_en && bus_addr != SEL_KEYS) |-> bus_data_oe);

endmodule

// File: tb/sim_matrix_scanner.sv
module sim_matrix_scanner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_tick = 1'b0;
    logic        led_wr_en = 1'b0;
    logic [2:0]  led_wr_row = '0;
    logic [7:0]  led_wr_data = '0;
    logic [23:0] key_state;
    logic [2:0]  bus_addr;
    logic        bus_dec_en;
    logic [7:0]  bus_data_out;
    logic        bus_data_oe;
    logic [7:0]  bus_data_in;

    always #5 clk = ~clk;

    matrix_scanner u0 (
        .clk(clk), .rst(rst), .scan_tick(scan_tick),
        .led_wr_en(led_wr_en), .led_wr_row(led_wr_row), .led_wr_data(led_wr_data),
        .key_state(key_state), .bus_addr(bus_addr), .bus_dec_en(bus_dec_en),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in)
    );

    int checks = 0;
    int fails  = 0;

    // bench-side world: external latches and key matrix
    logic [7:0] col_l = '0;
    logic [7:0] row_l = 8'hFF;
    logic [2:0][7:0] kmap = '0;
    logic [7:0] leds [0:4];
    logic [2:0][7:0] key_exp = '0;
    int exp_c = 0;
    int exp_s = 0;

    always_comb begin
        for (int c = 0; c < 8; c++) begin
            logic hit;
            hit = 1'b0;
            for (int r = 0; r < 3; r++)
                if (kmap[r][c] && !row_l[5+r]) hit = 1'b1;
            bus_data_in[c] = ~hit;
        end
    end

    // strobe recorder and select-change monitor
    logic [2:0] s_addr [0:15];
    logic [7:0] s_data [0:15];
    logic       s_oe   [0:15];
    int         n_str = 0;
    int         rule_viol = 0;
    int         oe_viol = 0;
    logic [2:0] prev_addr = 3'd3;
    logic       prev_en = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_dec_en) begin
                if (n_str < 16) begin
                    s_addr[n_str] = bus_addr;
                    s_data[n_str] = bus_data_out;
                    s_oe[n_str]   = bus_data_oe;
                end
                n_str = n_str + 1;
                if (bus_data_oe && bus_addr == 3'd1) col_l = bus_data_out;
                if (bus_data_oe && bus_addr == 3'd2) row_l = bus_data_out;
            end
            if (bus_addr != prev_addr && (bus_dec_en || prev_en)) rule_viol++;
            if (bus_addr == 3'd3 && bus_data_oe) oe_viol++;
            prev_addr = bus_addr;
            prev_en   = bus_dec_en;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_led(input int r, input logic [7:0] v);
        led_wr_row  = 3'(r);
        led_wr_data = v;
        led_wr_en   = 1'b1;
        @(negedge clk);
        led_wr_en   = 1'b0;
        if (r < 5) leds[r] = v;
    endtask

    function automatic logic [7:0] exp_row_latch(input int c, input int s);
        logic [4:0] lb;
        logic [2:0] kb;
        for (int r = 0; r < 5; r++) lb[r] = ~leds[r][c];
        kb = ~(3'b001 << s);
        return {kb, lb};
    endfunction

    // run one step and check its whole bus trace
    task automatic do_step(input bit mid_tick);
        logic [7:0] er;
        er = exp_row_latch(exp_c, exp_s);
        n_str = 0;
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        if (mid_tick) begin
            repeat (4) @(negedge clk);
            scan_tick = 1'b1;
            @(negedge clk);
            scan_tick = 1'b0;
            repeat (8) @(negedge clk);
        end else begin
            repeat (13) @(negedge clk);
        end
        check(n_str == 4, "R2 access count", n_str, 4);
        check(s_addr[0] == 3'd1 && s_addr[1] == 3'd2 && s_addr[2] == 3'd1 && s_addr[3] == 3'd3,
              "R2 access order", {s_addr[0], s_addr[1], s_addr[2], s_addr[3]}, 12'o1213);
        check(s_data[0] == 8'h00, "R2 blank first", s_data[0], 0);
        check(s_data[1][4:0] == er[4:0], "R5 led rows", s_data[1][4:0], er[4:0]);
        check(s_data[1][7:5] == er[7:5], "R6 key row code", s_data[1][7:5], er[7:5]);
        check(s_data[2] == (8'h01 << exp_c), "R5 column onehot", s_data[2], 8'h01 << exp_c);
        check(s_oe[0] && s_oe[1] && s_oe[2] && !s_oe[3], "R4 drive/release",
              {s_oe[0], s_oe[1], s_oe[2], s_oe[3]}, 4'b1110);
        check(bus_addr == 3'd3 && !bus_dec_en, "R2 back to idle", {bus_addr, bus_dec_en}, 4'b0110);
        key_exp[exp_s] = kmap[exp_s];
        check(key_state == key_exp, "R7 key map", key_state, key_exp);
        exp_c = (exp_c + 1) % 8;
        exp_s = (exp_s + 1) % 3;
    endtask

    task automatic t_reset();
        check(bus_addr == 3'd3, "R1 idle select", bus_addr, 3);
        check(!bus_dec_en && !bus_data_oe, "R1 enables low", {bus_dec_en, bus_data_oe}, 0);
        check(bus_data_out == 8'h00, "R1 data zero", bus_data_out, 0);
        check(key_state == '0, "R1 keys clear", key_state, 0);
    endtask

    task automatic t_led_scan();
        set_led(0, 8'b1000_0001);
        set_led(1, 8'b0101_0101);
        set_led(2, 8'b1111_0000);
        set_led(3, 8'b0000_0000);
        set_led(4, 8'b1111_1111);
        for (int i = 0; i < 9; i++) do_step(1'b0);
    endtask

    task automatic t_led_oob();
        // R8: row index 5..7 ignored; rows unchanged in next steps
        set_led(6, 8'h00);
        set_led(5, 8'h00);
        set_led(7, 8'h00);
        for (int i = 0; i < 2; i++) do_step(1'b0);
        set_led(3, 8'hFF);
        do_step(1'b0); // R8 in-range write takes effect
    endtask

    task automatic t_keys();
        kmap[0] = 8'b0000_0011;
        kmap[1] = 8'b1000_0000;
        kmap[2] = 8'b0010_0100;
        for (int i = 0; i < 3; i++) do_step(1'b0);
        check(key_state == 24'h248003, "R7 full map", key_state, 24'h248003);
        kmap = '1;
        do_step(1'b0); // only one row may follow the change
        kmap[0] = 8'h00; kmap[1] = 8'h5A; kmap[2] = 8'h00;
        for (int i = 0; i < 3; i++) do_step(1'b0);
    endtask

    task automatic t_tick_ignored();
        do_step(1'b1); // R9 second tick inside a step
        repeat (3) @(negedge clk);
        check(n_str == 4 && bus_addr == 3'd3 && !bus_dec_en, "R9 no extra step", n_str, 4);
        do_step(1'b0); // R9 next step uses the following column and row
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 5; r++) leds[r] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_led_scan();
        t_led_oob();
        t_keys();
        t_tick_ignored();
        check(rule_viol == 0, "R3 select changed while enabled", rule_viol, 0);
        check(oe_viol == 0, "R4 bus driven at key port", oe_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule